// File: doc/BRIEF.md
# Video Clock Rate Classifier and Output Path Controller

The block watches an incoming video clock. It decides whether the clock runs at one of three nominal rates: 27 MHz, 74.25 MHz or 148.5 MHz. It then chooses how a downstream clock multiplexer should route that clock. The block counts rising edges of the incoming clock over a fixed window of reference-clock cycles. The count crosses into the reference domain as a Gray code through a two-flop synchronizer. Each window's count is then compared against a band of ±0.4 % around the count expected for each nominal rate.

A two-bit mode input either accepts any of the three rates or restricts locking to one of them. Lock is granted only when two consecutive windows agree on the same accepted rate. A single window that fails drops lock at once. When lock is held, the multiplexer select picks the cleaned clock at the locked rate. If a doubling request is present and the locked rate is 74.25 MHz, the select picks the doubled clock instead. In every other case the select chooses the raw input in bypass. The mode and doubling inputs are quasi-static controls in the reference domain.

Top module: `vclk_rate_supervisor`

## Requirements
- R1: While reset is asserted, and after reset until lock is first granted, `lock` is 0, `rate_code` is 2'b00 and `path_sel` is 2'b00.
- R2: The first window boundary after reset only records a baseline. Lock cannot rise before the end of the third window after reset, which means two fully measured windows.
- R3: A window count within NOM ± NOM·TOL_PPM/10^6 (inclusive, integer-truncated tolerance) of NOM_LO, NOM_MID or NOM_HI is classed as 27, 74.25 or 148.5 MHz respectively. Any other count, including zero from a stopped clock, is classed as other.
- R4: With `mode_sel` = 2'b00 (automatic), any of the three recognised rates can be locked.
- R5: With `mode_sel` = 2'b01, 2'b10 or 2'b11, lock is possible only at 27, 74.25 or 148.5 MHz respectively. Any other rate leaves lock low.
- R6: Lock rises at a window boundary only when that window and the one before it are classed as the same rate and that rate is accepted by the mode.
- R7: A window that is classed as other, not accepted by the mode, or different from the locked rate, clears lock within 2 cycles of that boundary.
- R8: Whenever `lock` is 0, `path_sel` is 2'b00 (bypass, raw input) and `rate_code` is 2'b00.
- R9: While locked without doubling, `path_sel` is 2'b01 (cleaned clock) and `rate_code` gives the locked rate: 2'b01 for 27, 2'b10 for 74.25, 2'b11 for 148.5.
- R10: While locked at 74.25 MHz with `dbl_req` high, `path_sel` is 2'b10 (doubled clock) and `rate_code` is 2'b11. At any other locked rate, and whenever unlocked, `dbl_req` has no effect on any output.
- R11: A change of `dbl_req` or `mode_sel` reaches the outputs within 2 reference cycles without waiting for a window. A mode that no longer accepts the locked rate drops `lock` at once, and a mode that accepts it again restores `lock` until the next window decides.
- R12: The incoming edge counter crosses clock domains in Gray code, changing by at most one bit per incoming-clock cycle, so that every sample taken in the reference domain is a valid count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fixed reference clock that times the measurement window |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| in_clk | input | 1 | Incoming video clock being measured |
| mode_sel | input | 2 | 00 automatic, 01 fixed 27 MHz, 10 fixed 74.25 MHz, 11 fixed 148.5 MHz |
| dbl_req | input | 1 | Request to double the output clock |
| lock | output | 1 | High while a cleaned clock is selected |
| rate_code | output | 2 | Rate of the selected output clock: 00 bypass, 01 27 MHz, 10 74.25 MHz, 11 148.5 MHz |
| path_sel | output | 2 | Multiplexer select: 00 bypass, 01 cleaned, 10 doubled |

## Verification
A corrupted window counter or baseline shows up as a wrong class at the next boundary. Lock then fails to rise, or falls, within one window length. A fault in the agreement history shows as lock rising one window too early or too late. The bench aligns its clock changes to window boundaries so that it can tell the two apart. A fault in the output decode shows as a wrong `path_sel` or `rate_code` within two reference cycles of toggling `dbl_req` or `mode_sel`. That fault is therefore exposed without waiting for a window.

// File: rtl/vrc_pkg.sv
`timescale 1ps/1ps
package vrc_pkg;

  typedef enum logic [1:0] {
    RATE_NONE = 2'b00,
    RATE_27   = 2'b01,
    RATE_74   = 2'b10,
    RATE_148  = 2'b11
  } rate_e;

  typedef enum logic [1:0] {
    PATH_BYPASS = 2'b00,
    PATH_CLEAN  = 2'b01,
    PATH_DOUBLE = 2'b10
  } path_e;

  localparam logic [1:0] MODE_AUTO = 2'b00;

  // A fixed mode uses the same code as the rate it accepts.
  function automatic logic mode_accepts(logic [1:0] mode, rate_e r);
    return (r != RATE_NONE) && ((mode == MODE_AUTO) || (mode == logic'(r[1:0]) ? 1'b1 : mode == r));
  endfunction

endpackage

// File: rtl/vrc_rst_sync.sv
`timescale 1ps/1ps
module vrc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shf_q;
  logic [STAGES-1:0] shf_d;

  always_comb begin
    shf_d = {shf_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shf_q <= '0;
    else        shf_q <= shf_d;
  end

  assign rst_sync_n = shf_q[STAGES-1];

endmodule

// File: rtl/vrc_edge_meter.sv
`timescale 1ps/1ps
module vrc_edge_meter #(
  parameter int WIN_CYCLES = 5000,
  parameter int CNT_W      = 15
) (
  input  logic             ref_clk,
  input  logic             ref_rst_n,
  input  logic             in_clk,
  input  logic             in_rst_n,
  output logic [CNT_W-1:0] meas_cnt,
  output logic             meas_vld
);

  localparam int WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);

  // ---------------- incoming-clock domain ----------------
  logic [CNT_W-1:0] bin_q, bin_d;
  logic [CNT_W-1:0] gray_q, gray_d;

  always_comb begin
    bin_d  = bin_q + 1'b1;
    gray_d = bin_q ^ (bin_q >> 1);
  end

  always_ff @(posedge in_clk or negedge in_rst_n) begin
    if (!in_rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  // ---------------- reference domain ----------------
  logic [CNT_W-1:0] gs1_q, gs2_q;
  logic [CNT_W-1:0] samp_bin;
  logic [WIN_W-1:0] win_q, win_d;
  logic             win_end;
  logic [CNT_W-1:0] base_q, base_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             primed_q, primed_d;
  logic             vld_q, vld_d;

  always_comb begin
    samp_bin[CNT_W-1] = gs2_q[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) begin
      samp_bin[i] = samp_bin[i+1] ^ gs2_q[i];
    end
  end

  always_comb begin
    win_end  = (win_q == WIN_LAST);
    win_d    = win_end ? '0 : win_q + 1'b1;
    base_d   = samp_bin;
    cnt_d    = samp_bin - base_q;
    primed_d = 1'b1;
    vld_d    = win_end & primed_q;
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      gs1_q    <= '0;
      gs2_q    <= '0;
      win_q    <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
      primed_q <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      gs1_q <= gray_q;
      gs2_q <= gs1_q;
      win_q <= win_d;
      vld_q <= vld_d;
      if (win_end) begin
        base_q   <= base_d;
        primed_q <= primed_d;
        if (primed_q) cnt_q <= cnt_d;
      end
    end
  end

  assign meas_cnt = cnt_q;
  assign meas_vld = vld_q;

  // R12: the crossing word moves one Gray step at a time
  p_gray_step_r12: assert property (@(posedge in_clk) disable iff (!in_rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);

  // R2: no count is reported before a baseline was taken
  p_primed_first_r2: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    meas_vld |-> primed_q);

  // R2: each report lasts a single cycle
  p_single_pulse_r2: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    meas_vld |=> !meas_vld);

endmodule

// File: rtl/vrc_rate_sort.sv
`timescale 1ps/1ps
module vrc_rate_sort
  import vrc_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int NOM_LO  = 1080,
  parameter int NOM_MID = 2970,
  parameter int NOM_HI  = 5940,
  parameter int TOL_PPM = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  output rate_e            rate
);

  localparam int NBANDS = 3;
  localparam int NOMS [NBANDS] = '{NOM_LO, NOM_MID, NOM_HI};

  logic [NBANDS-1:0] hit;

  for (genvar g = 0; g < NBANDS; g++) begin : g_band
    localparam int NOM  = NOMS[g];
    localparam int TOL  = int'((longint'(NOM) * longint'(TOL_PPM)) / 64'sd1000000);
    localparam logic [CNT_W-1:0] LO = CNT_W'(NOM - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(NOM + TOL);
    assign hit[g] = (cnt >= LO) && (cnt <= HI);
  end

  always_comb begin
    if      (hit[0]) rate = RATE_27;
    else if (hit[1]) rate = RATE_74;
    else if (hit[2]) rate = RATE_148;
    else             rate = RATE_NONE;
  end

  // R3: the tolerance bands never overlap
  p_band_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: rtl/vrc_lock_ctl.sv
`timescale 1ps/1ps
module vrc_lock_ctl
  import vrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       dbl_req,
  input  logic       meas_vld,
  input  rate_e      meas_rate,
  output logic       lock_o,
  output logic [1:0] rate_code_o,
  output logic [1:0] path_sel_o
);

  rate_e prev_rate_q, prev_rate_d;
  logic  prev_vld_q, prev_vld_d;
  logic  lock_q, lock_d;
  rate_e lock_rate_q, lock_rate_d;

  logic  win_match, win_agree, live_ok;

  logic  out_lock_q, out_lock_d;
  rate_e out_rc_q, out_rc_d;
  path_e out_path_q, out_path_d;

  // window decision
  always_comb begin
    win_match   = (meas_rate != RATE_NONE) &&
                  ((mode_sel == MODE_AUTO) || (mode_sel == meas_rate));
    win_agree   = prev_vld_q && (prev_rate_q == meas_rate);
    prev_rate_d = prev_rate_q;
    prev_vld_d  = prev_vld_q;
    lock_d      = lock_q;
    lock_rate_d = lock_rate_q;
    if (meas_vld) begin
      prev_rate_d = meas_rate;
      prev_vld_d  = 1'b1;
      lock_d      = win_match && win_agree;
      if (win_match && win_agree) lock_rate_d = meas_rate;
    end
  end

  // live output decode
  always_comb begin
    live_ok    = lock_q && (lock_rate_q != RATE_NONE) &&
                 ((mode_sel == MODE_AUTO) || (mode_sel == lock_rate_q));
    out_lock_d = live_ok;
    out_rc_d   = RATE_NONE;
    out_path_d = PATH_BYPASS;
    if (live_ok) begin
      if (dbl_req && (lock_rate_q == RATE_74)) begin
        out_rc_d   = RATE_148;
        out_path_d = PATH_DOUBLE;
      end else begin
        out_rc_d   = lock_rate_q;
        out_path_d = PATH_CLEAN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rate_q <= RATE_NONE;
      prev_vld_q  <= 1'b0;
      lock_q      <= 1'b0;
      lock_rate_q <= RATE_NONE;
      out_lock_q  <= 1'b0;
      out_rc_q    <= RATE_NONE;
      out_path_q  <= PATH_BYPASS;
    end else begin
      if (meas_vld) begin
        prev_rate_q <= prev_rate_d;
        prev_vld_q  <= prev_vld_d;
        lock_q      <= lock_d;
        lock_rate_q <= lock_rate_d;
      end
      out_lock_q <= out_lock_d;
      out_rc_q   <= out_rc_d;
      out_path_q <= out_path_d;
    end
  end

  assign lock_o      = out_lock_q;
  assign rate_code_o = out_rc_q;
  assign path_sel_o  = out_path_q;

  // R6: lock only rises right after a window report
  p_rise_at_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(meas_vld));

  // R7: a window that fails the mode clears lock on the next edge
  p_fail_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_vld && !win_match) |=> !lock_q);

  // R8: bypass always goes with an unlocked, empty code
  p_bypass_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_path_q == PATH_BYPASS) |-> (!out_lock_q && out_rc_q == RATE_NONE));

  // R10: doubling only follows a lock at the middle rate with the request present
  p_double_mid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_path_q == PATH_DOUBLE) |-> ($past(lock_rate_q) == RATE_74 && $past(dbl_req)));

endmodule

// File: rtl/vclk_rate_supervisor.sv
`timescale 1ps/1ps
module vclk_rate_supervisor
  import vrc_pkg::*;
#(
  parameter int WIN_CYCLES = 5000,
  parameter int NOM_LO     = 1080,
  parameter int NOM_MID    = 2970,
  parameter int NOM_HI     = 5940,
  parameter int TOL_PPM    = 4000,
  parameter int SYNC_STG   = 2
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       in_clk,
  input  logic [1:0] mode_sel,
  input  logic       dbl_req,
  output logic       lock,
  output logic [1:0] rate_code,
  output logic [1:0] path_sel
);

  localparam int CNT_W = $clog2(NOM_HI * 2 + 1) + 1;

  logic             ref_rst_n;
  logic             in_rst_n;
  logic [CNT_W-1:0] meas_cnt;
  logic             meas_vld;
  rate_e            meas_rate;

  vrc_rst_sync #(.STAGES(SYNC_STG)) u_rst_ref (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .rst_sync_n (ref_rst_n)
  );

  vrc_rst_sync #(.STAGES(SYNC_STG)) u_rst_in (
    .clk        (in_clk),
    .rst_n      (rst_n),
    .rst_sync_n (in_rst_n)
  );

  vrc_edge_meter #(
    .WIN_CYCLES (WIN_CYCLES),
    .CNT_W      (CNT_W)
  ) u_meter (
    .ref_clk   (ref_clk),
    .ref_rst_n (ref_rst_n),
    .in_clk    (in_clk),
    .in_rst_n  (in_rst_n),
    .meas_cnt  (meas_cnt),
    .meas_vld  (meas_vld)
  );

  vrc_rate_sort #(
    .CNT_W   (CNT_W),
    .NOM_LO  (NOM_LO),
    .NOM_MID (NOM_MID),
    .NOM_HI  (NOM_HI),
    .TOL_PPM (TOL_PPM)
  ) u_sort (
    .clk   (ref_clk),
    .rst_n (ref_rst_n),
    .cnt   (meas_cnt),
    .rate  (meas_rate)
  );

  vrc_lock_ctl u_ctl (
    .clk         (ref_clk),
    .rst_n       (ref_rst_n),
    .mode_sel    (mode_sel),
    .dbl_req     (dbl_req),
    .meas_vld    (meas_vld),
    .meas_rate   (meas_rate),
    .lock_o      (lock),
    .rate_code_o (rate_code),
    .path_sel_o  (path_sel)
  );

endmodule

// File: tb/vclk_rate_supervisor_tb.sv
`timescale 1ps/1ps
module vclk_rate_supervisor_tb;

  localparam int W       = 2500;
  localparam int REF_HALF = 4000;   // 125 MHz

  logic       ref_clk = 1'b0;
  logic       in_clk  = 1'b0;
  logic       rst_n   = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       dbl_req  = 1'b0;
  logic       lock;
  logic [1:0] rate_code;
  logic [1:0] path_sel;

  int in_half = 6734;
  int cyc = 0;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  vclk_rate_supervisor #(
    .WIN_CYCLES (W),
    .NOM_LO     (540),
    .NOM_MID    (1485),
    .NOM_HI     (2970),
    .TOL_PPM    (4000)
  ) u_dut (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .in_clk    (in_clk),
    .mode_sel  (mode_sel),
    .dbl_req   (dbl_req),
    .lock      (lock),
    .rate_code (rate_code),
    .path_sel  (path_sel)
  );

  always #(REF_HALF) ref_clk = ~ref_clk;

  always begin
    if (in_half == 0) #2000;
    else begin
      #(in_half);
      in_clk = ~in_clk;
    end
  end

  always @(posedge ref_clk) begin
    if (rst_n) cyc <= cyc + 1;
  end

  // stimulus index -> half period (ps) and class (0 other, 1 27, 2 74.25, 3 148.5)
  function automatic int half_of(int idx);
    case (idx)
      0: return 18519;  // 27 MHz
      1: return 6734;   // 74.25 MHz
      2: return 3367;   // 148.5 MHz
      3: return 10000;  // 50 MHz
      4: return 5000;   // 100 MHz
      5: return 0;      // stopped
      6: return 6714;   // 74.25 MHz +0.3 %
      default: return 6775; // 74.25 MHz -0.6 %
    endcase
  endfunction

  function automatic int cls_of(int idx);
    case (idx)
      0: return 1;
      1: return 2;
      2: return 3;
      6: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic exp_lock(logic [1:0] m, int c);
    return (c != 0) && ((m == 2'b00) || (int'(m) == c));
  endfunction

  function automatic logic [1:0] exp_rc(logic [1:0] m, int c, logic d);
    if (!exp_lock(m, c)) return 2'b00;
    if (d && c == 2) return 2'b11;
    return 2'(c);
  endfunction

  function automatic logic [1:0] exp_path(logic [1:0] m, int c, logic d);
    if (!exp_lock(m, c)) return 2'b00;
    if (d && c == 2) return 2'b10;
    return 2'b01;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cyc %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic chk_all(string req, logic [1:0] m, int c, logic d);
    chk(req, "lock",      int'(lock),      int'(exp_lock(m, c)));
    chk(req, "rate_code", int'(rate_code), int'(exp_rc(m, c, d)));
    chk(req, "path_sel",  int'(path_sel),  int'(exp_path(m, c, d)));
  endtask

  task automatic goto(int k, int off);
    while (cyc < k * W + off) @(negedge ref_clk);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  initial begin
    void'($urandom(32'd51823));
    // R1: outputs idle while held in reset
    settle(5);
    chk("R1", "lock in reset", int'(lock), 0);
    chk("R1", "rate_code in reset", int'(rate_code), 0);
    chk("R1", "path_sel in reset", int'(path_sel), 0);
    rst_n = 1'b1;

    goto(0, 100);
    chk_all("R1", 2'b00, 0, 1'b0);

    // R2: two windows measured, lock still low right before third boundary
    goto(3, -50);
    chk("R2", "lock before third boundary", int'(lock), 0);
    goto(3, 32);
    chk_all("R4_R9", 2'b00, 2, 1'b0);

    // R10 / R11: doubling request takes effect without a window
    dbl_req = 1'b1;
    settle(3);
    chk_all("R10_R11", 2'b00, 2, 1'b1);
    dbl_req = 1'b0;
    settle(3);
    chk_all("R11", 2'b00, 2, 1'b0);

    // R11 / R5: mode change gates lock at once
    mode_sel = 2'b01;
    settle(3);
    chk_all("R11_R5", 2'b01, 2, 1'b0);
    mode_sel = 2'b10;
    settle(3);
    chk_all("R11", 2'b10, 2, 1'b0);

    // R7: mixed window (switch to 27 under fixed 74.25) drops lock
    goto(4, -98);
    in_half = half_of(0);
    goto(4, 32);
    chk("R7", "lock after failing window", int'(lock), 0);
    goto(5, 32);
    chk_all("R5", 2'b10, 0, 1'b0);
    goto(6, 32);
    chk_all("R5", 2'b10, 0, 1'b0);
    settle(18);
    mode_sel = 2'b01;
    goto(7, 32);
    chk_all("R5_R9", 2'b01, 1, 1'b0);
    dbl_req = 1'b1;
    settle(3);
    chk_all("R10", 2'b01, 1, 1'b1);
    dbl_req = 1'b0;
    settle(5);
    mode_sel = 2'b00;

    // R6: one agreeing window after a change is not enough
    goto(8, -98);
    in_half = half_of(2);
    goto(8, 32);
    chk("R7", "lock after rate change", int'(lock), 0);
    goto(9, 32);
    chk("R6", "lock after single good window", int'(lock), 0);
    goto(10, 32);
    chk_all("R6_R4", 2'b00, 3, 1'b0);
    dbl_req = 1'b1;
    settle(3);
    chk_all("R10", 2'b00, 3, 1'b1);
    settle(20);
    mode_sel = 2'b10;

    // R3: edge of tolerance band
    goto(11, -98);
    in_half = half_of(6);
    goto(13, 32);
    chk_all("R3_R12_R10", 2'b10, 2, 1'b1);
    goto(14, -98);
    in_half = half_of(7);
    goto(16, 32);
    chk_all("R3", 2'b10, 0, 1'b1);
    chk("R8", "path when unlocked with request", int'(path_sel), 0);

    // randomized steady-state scenarios
    for (int s = 0; s < 16; s++) begin
      int idx;
      int k;
      logic [1:0] m;
      logic d;
      k   = 18 + 3 * s;
      idx = int'($urandom_range(0, 7));
      m   = 2'($urandom_range(0, 3));
      d   = 1'($urandom_range(0, 1));
      goto(k, -98);
      in_half  = half_of(idx);
      mode_sel = m;
      dbl_req  = d;
      goto(k + 2, 32);
      chk_all("R3_R5_R8_R9_R10", m, cls_of(idx), d);
    end

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(64'd195000 * 2 * REF_HALF);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule